// File: doc/BRIEF.md
# Circulant Message Address Generator

This block produces word addresses into the message memories of a semi-parallel iterative decoder. The decoder's parity check matrix is built from square sub-blocks, and each sub-block is an identity matrix rotated to the right by some amount. The only thing stored per sub-block is that rotation. Every nonzero position is rebuilt at run time by adding a running counter to the rotation. Because the sub-block size is a power of two, the modulo step is simply the natural wrap of a narrow counter. Several messages share one memory word, and all rotations are multiples of that packing factor, so the generator counts in words rather than in messages.

There are `NUM_MEM` address lanes, one per message memory. When the controller pulses `start`, the block captures the rotation table and the mode. In check-side mode each lane begins at its own rotation expressed in words. In linear mode every lane counts from zero, which is the single unrotated sweep used on the bit-node side. After the start, `addr_valid` is high for one full sweep of the sub-block, which is `SUB_SIZE/PACK` cycles. `done` then rises and stays high until the next accepted start.

Top module: `circ_addr_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it, `addr_valid` and `done` are 0 and every lane address is 0.
- R2: A start accepted at a clock edge makes `addr_valid` go high from that edge on, for exactly WORDS = SUB_SIZE/PACK consecutive cycles (8 with the defaults).
- R3: In check-side mode (`linear`=0 at the start), lane i on the k-th valid cycle (k counted from 0) outputs (S_i/PACK + k) mod WORDS. S_i is the rotation in messages taken from `shift_tbl[i*SW +: SW]`, with SW = log2(SUB_SIZE). The address of lane i is `addr_out[i*WAW +: WAW]`, with WAW = log2(WORDS).
- R4: A lane address wraps from WORDS-1 back to 0 inside a sweep, so a lane whose rotation is close to the top of the sub-block still produces WORDS distinct addresses.
- R5: The low log2(PACK) bits of each rotation have no effect. A rotation of 13 gives the same addresses as a rotation of 8.
- R6: In linear mode (`linear`=1 at the start), every lane outputs k on the k-th valid cycle, whatever the rotation table holds.
- R7: `done` rises in the cycle after the last valid cycle and stays high, with `addr_valid` low, until the next accepted start. `done` is 0 in every valid cycle.
- R8: While a sweep is running, `start`, `linear` and `shift_tbl` are ignored. The sweep runs to its end with the addresses it captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted when no sweep is running) |
| linear | input | 1 | Mode sampled at start: 1 = unrotated count, 0 = per-lane rotation |
| shift_tbl | input | NUM_MEM*SW | Per-lane rotation in messages, lane i in bits [i*SW +: SW] |
| addr_out | output | NUM_MEM*WAW | Per-lane word address, lane i in bits [i*WAW +: WAW] |
| addr_valid | output | 1 | Addresses on `addr_out` are valid this cycle |
| done | output | 1 | Sweep complete; held until the next accepted start |

## Verification
Faults in this block show up quickly at the ports. A wrong lane base, or bits of the rotation that were captured badly, gives a wrong address on the very first valid cycle. A fault in the sweep counter shows up as a burst that is one cycle too short or too long, seen at the falling edge of `addr_valid` and at `done`. A start that leaks through during a sweep reloads the lanes, and the next cycle shows an address jump instead of a +1 step. The bench compares every lane on every valid cycle against values it computes from the rotation table. This exposes wrap and truncation errors at the exact cycle where they happen.

// File: rtl/circ_pkg.sv
package circ_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sweep_state_t;
endpackage

// File: rtl/circ_seq_ctrl.sv
module circ_seq_ctrl
  import circ_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int WAW = $clog2(WORDS)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic valid,
  output logic done
);
  sweep_state_t     state;
  logic [WAW-1:0]   left;
  logic             accept;

  // a start is taken only when no sweep is in flight
  assign accept = start && (state != ST_RUN);
  assign load   = accept;
  assign step   = (state == ST_RUN) && (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      left  <= '0;
      valid <= 1'b0;
      done  <= 1'b0;
    end else if (accept) begin
      state <= ST_RUN;
      left  <= WAW'(WORDS - 1);
      valid <= 1'b1;
      done  <= 1'b0;
    end else if (state == ST_RUN) begin
      if (left == '0) begin
        state <= ST_DONE;
        valid <= 1'b0;
        done  <= 1'b1;
      end else begin
        left <= left - WAW'(1);
      end
    end
  end
endmodule

// File: rtl/circ_lane.sv
module circ_lane #(
  parameter int SUB_SIZE = 64,
  parameter int PACK     = 8,
  localparam int WORDS = SUB_SIZE / PACK,
  localparam int SW    = $clog2(SUB_SIZE),
  localparam int PW    = $clog2(PACK),
  localparam int WAW   = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           linear,
  input  logic [SW-1:0]  shift_in,
  output logic [WAW-1:0] addr
);
  // rotation in words: drop the in-word bits, which must be zero anyway
  logic [WAW-1:0] base_word;
  assign base_word = shift_in[SW-1:PW];

  // modulo WORDS comes from the natural wrap of a WAW-bit register
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= linear ? '0 : base_word;
    else if (step) addr <= addr + WAW'(1);
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int SUB_SIZE = 64,
  parameter int PACK     = 8,
  parameter int NUM_MEM  = 6,
  localparam int WORDS = SUB_SIZE / PACK,
  localparam int SW    = $clog2(SUB_SIZE),
  localparam int WAW   = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   linear,
  input  logic [NUM_MEM*SW-1:0]  shift_tbl,
  output logic [NUM_MEM*WAW-1:0] addr_out,
  output logic                   addr_valid,
  output logic                   done
);
  logic load, step;

  circ_seq_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .valid (addr_valid),
    .done  (done)
  );

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_lane
    circ_lane #(.SUB_SIZE(SUB_SIZE), .PACK(PACK)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .step     (step),
      .linear   (linear),
      .shift_in (shift_tbl[i*SW +: SW]),
      .addr     (addr_out[i*WAW +: WAW])
    );
  end
endmodule

// File: rtl/circ_addr_chk.sv
module circ_addr_chk #(
  parameter int SUB_SIZE = 64,
  parameter int PACK     = 8,
  parameter int NUM_MEM  = 6,
  localparam int WORDS = SUB_SIZE / PACK,
  localparam int WAW   = $clog2(WORDS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic [NUM_MEM*WAW-1:0] addr_out,
  input logic                   addr_valid,
  input logic                   done
);
  // number of valid cycles seen so far in the current burst
  logic [WAW+1:0] run;
  always_ff @(posedge clk) begin
    if (rst)             run <= '0;
    else if (addr_valid) run <= run + 1'b1;
    else                 run <= '0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!addr_valid && !done && addr_out == '0));

  assert_burst_bound_R2: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> (run < (WAW+2)'(WORDS)));

  assert_burst_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(addr_valid) |-> (run == (WAW+2)'(WORDS)) && done);

  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(addr_valid && done));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_chk
    assert_step_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (addr_valid && $past(addr_valid)) |->
        (addr_out[i*WAW +: WAW] == $past(addr_out[i*WAW +: WAW]) + WAW'(1)));
  end
endmodule

bind circ_addr_gen circ_addr_chk #(
  .SUB_SIZE(SUB_SIZE), .PACK(PACK), .NUM_MEM(NUM_MEM)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .addr_out   (addr_out),
  .addr_valid (addr_valid),
  .done       (done)
);

// File: tb/sim_circ_addr_gen.sv
module sim_circ_addr_gen;
  localparam int SUB = 64;
  localparam int PK  = 8;
  localparam int NM  = 6;
  localparam int SW  = 6;
  localparam int WAW = 3;
  localparam int WORDS = SUB / PK;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              linear = 1'b0;
  logic [NM*SW-1:0]  shift_tbl = '0;
  logic [NM*WAW-1:0] addr_out;
  logic              addr_valid;
  logic              done;

  int n_chk = 0;
  int n_bad = 0;

  circ_addr_gen #(.SUB_SIZE(SUB), .PACK(PK), .NUM_MEM(NM)) u0 (
    .clk(clk), .rst(rst), .start(start), .linear(linear),
    .shift_tbl(shift_tbl), .addr_out(addr_out),
    .addr_valid(addr_valid), .done(done)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one sweep; called at a falling edge; poke >= 0 pulses start and scrambles inputs mid-sweep
  task automatic run_burst(input string req, input int sh[NM], input bit lin, input int poke);
    for (int i = 0; i < NM; i++) shift_tbl[i*SW +: SW] = SW'(sh[i]);
    linear = lin;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < WORDS; k++) begin
      check_eq({req, " R2"}, $sformatf("valid k=%0d", k), int'(addr_valid), 1);
      check_eq({req, " R7"}, $sformatf("done low k=%0d", k), int'(done), 0);
      for (int i = 0; i < NM; i++) begin
        int exp;
        exp = lin ? k : ((sh[i] / PK) + k) % WORDS;
        check_eq(req, $sformatf("lane %0d k=%0d", i, k), int'(addr_out[i*WAW +: WAW]), exp);
      end
      if (k == poke) begin
        start = 1'b1;
        shift_tbl = ~shift_tbl;
        linear = ~lin;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check_eq({req, " R2"}, "valid after sweep", int'(addr_valid), 0);
    check_eq({req, " R7"}, "done after sweep", int'(done), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_eq("R1", "valid in reset", int'(addr_valid), 0);
    check_eq("R1", "done in reset", int'(done), 0);
    check_eq("R1", "addr in reset", int'(addr_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "valid after reset", int'(addr_valid), 0);
    check_eq("R1", "done after reset", int'(done), 0);
  endtask

  task automatic t_rotated();
    int sh[NM] = '{0, 8, 16, 40, 56, 24};
    run_burst("R3 R4", sh, 1'b0, -1);
  endtask

  task automatic t_low_bits();
    int sh[NM] = '{7, 13, 23, 47, 63, 31};
    run_burst("R5", sh, 1'b0, -1);
  endtask

  task automatic t_linear();
    int sh[NM] = '{56, 48, 40, 32, 24, 8};
    run_burst("R6", sh, 1'b1, -1);
  endtask

  task automatic t_busy_start();
    int sh[NM] = '{24, 32, 0, 56, 8, 48};
    run_burst("R8", sh, 1'b0, 3);
    run_burst("R8 last", sh, 1'b1, WORDS - 1);
  endtask

  task automatic t_done_hold();
    int sh[NM] = '{48, 56, 8, 16, 24, 32};
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check_eq("R7", $sformatf("done held c=%0d", c), int'(done), 1);
      check_eq("R7", $sformatf("valid low c=%0d", c), int'(addr_valid), 0);
    end
    run_burst("R7 restart", sh, 1'b0, -1);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rotated();
    t_low_bits();
    t_linear();
    t_busy_start();
    t_done_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule